// File: doc/BRIEF.md
# Scratchpad EEPROM Command Controller

This block carries out the memory-level commands of a single-line serial memory device once the link layer has selected the device. The link layer hands it whole received bytes and takes whole bytes from it for the master's read slots. The block stages writes in a 32-byte scratchpad. It keeps a 16-bit target address and an end-offset/status byte. It commits one aligned 32-byte section of the scratchpad into an internal synchronous RAM only after a three-byte authorisation. It also streams RAM contents back to the master.

A controller with enumerated states does the work. `S_IDLE` waits for the select pulse, and `S_OPC` takes the function byte. A write passes through `S_WA_LO`, `S_WA_HI`, `S_WDATA` and, when the scratchpad fills, `S_WCRC`. A scratchpad read runs in `S_RS`. A copy goes through `S_CA`, `S_COPY` and `S_TOGGLE`. A memory read runs in `S_RA_LO`, `S_RA_HI`, then alternates between `S_RFETCH` and `S_RSEND`. `S_HALT` holds the device silent.

The transitions are as follows. A `line_rst` pulse leads from any state to `S_IDLE`. In `S_IDLE`, `sel` leads to `S_OPC`. In `S_OPC`, the opcode picks the next state, and an unknown opcode leads to `S_HALT`. Each address byte advances the address states. The 32nd scratchpad slot leads from `S_WDATA` to `S_WCRC`. The last header or data byte taken leads from `S_WCRC`, `S_RS` or `S_RSEND` to `S_HALT`. In `S_CA`, a mismatched or out-of-range authorisation leads to `S_HALT`. After 32 write cycles, `S_COPY` leads to `S_TOGGLE`.

Top module: `scratch_eeprom_ctrl`

## Requirements
- R1: After `rst_n` is released, `tx_avail` is low, and a scratchpad read returns target address 0x0000 and a status byte of 0x00.
- R2: Write command 0x0F takes the address low byte, then the high byte, then data. Data goes into scratchpad slots starting at address bits [4:0]. Status bits [4:0] hold the offset of the last slot written, and status bit 6 is always 0.
- R3: Status bit 7 (partial) is set when a write command is accepted and is cleared only when slot 31 is written.
- R4: When slot 31 is written, the block offers two bytes: the bitwise inverse of the CRC-16 low byte, then the inverse of the high byte. The CRC uses the reflected polynomial 0xA001, is processed LSB first, starts from 0, and covers the opcode through the last data byte. A write that stops early offers nothing.
- R5: Read command 0xAA returns the address low byte, the address high byte, the status byte, then scratchpad slots from address bits [4:0] to 31. After that, `tx_avail` stays low.
- R6: Copy command 0xAA-free opcode 0x55 expects three bytes equal to the address low byte, the address high byte and the status byte. On a match, status bit 5 (authorised) is set and all 32 slots are written to RAM at the address with bits [4:0] cleared. On a mismatch, nothing is written, bit 5 is unchanged and the block stays silent.
- R7: After a successful copy, the block offers 0xAA on every read (bits 0,1,0,1… LSB first) until `line_rst`.
- R8: Read-memory command 0xF0 takes two address bytes and streams RAM bytes from that address up to and including the last location, then drops `tx_avail`.
- R9: With a non-zero `READ_LIMIT`, a memory read stops after that many bytes.
- R10: A memory read that starts at or beyond `MEM_BYTES` returns 0xFF. A copy whose address is at or beyond `MEM_BYTES` is rejected and writes nothing.
- R11: An unknown opcode makes the block ignore all further bytes, without offering data, until `line_rst`. Its registers stay unchanged.
- R12: Accepting a write command clears status bit 5.
- R13: Bytes received while the block is not selected have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_rst | input | 1 | Link saw a bus reset pulse; aborts the command |
| sel | input | 1 | Device selected; the next byte is a function code |
| rx_vld | input | 1 | One-cycle strobe for a byte received from the master |
| rx_byte | input | 8 | Received byte |
| tx_avail | output | 1 | A byte is ready for the master's read slots |
| tx_byte | output | 8 | Byte to send, valid while `tx_avail` is high |
| tx_take | input | 1 | Link consumed `tx_byte` |

## Verification
The hardest state to reach is the authorised copy. The three echoed bytes must reproduce a status byte whose partial, authorised and end-offset bits depend on every earlier write. The stimulus reaches it by filling each RAM section with a full write and an exact echo, all driven from a bench model of the scratchpad. It also sends a deliberately wrong echo and an out-of-range section that aliases onto a filled one. The limited-read case uses a second instance with a small `READ_LIMIT` that is fed the same byte stream.

// File: rtl/sec_pkg.sv
package sec_pkg;
    localparam int SP_BYTES = 32;
    localparam int SP_OW    = $clog2(SP_BYTES);

    localparam logic [7:0] OP_WRITE_SP = 8'h0F;
    localparam logic [7:0] OP_READ_SP  = 8'hAA;
    localparam logic [7:0] OP_COPY_SP  = 8'h55;
    localparam logic [7:0] OP_READ_MEM = 8'hF0;
    localparam logic [7:0] TOGGLE_BYTE = 8'hAA;
    localparam logic [15:0] CRC_POLY_REF = 16'hA001;

    typedef enum logic [3:0] {
        S_IDLE, S_OPC, S_WA_LO, S_WA_HI, S_WDATA, S_WCRC, S_RS,
        S_CA, S_COPY, S_TOGGLE, S_RA_LO, S_RA_HI, S_RFETCH, S_RSEND, S_HALT
    } sec_state_e;
endpackage

// File: rtl/sec_crc16_step.sv
module sec_crc16_step #(
    parameter logic [15:0] POLY = 16'hA001
) (
    input  logic [15:0] crc_in,
    input  logic [7:0]  din,
    output logic [15:0] crc_out
);
    always_comb begin
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ din[i];
            c  = c >> 1;
            if (fb) c = c ^ POLY;
        end
        crc_out = c;
    end
endmodule

// File: rtl/sec_scratch.sv
module sec_scratch #(
    parameter int BYTES = 32,
    localparam int OW = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [OW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [OW-1:0] ridx,
    output logic [7:0]    rdata
);
    logic [7:0] slot [BYTES];

    always_ff @(posedge clk) begin
        if (we) slot[widx] <= wdata;
    end

    assign rdata = slot[ridx];
endmodule

// File: rtl/sec_sync_ram.sv
module sec_sync_ram #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        if (re) rdata <= cells[raddr];
    end
endmodule

// File: rtl/scratch_eeprom_ctrl.sv
module scratch_eeprom_ctrl
    import sec_pkg::*;
#(
    parameter int MEM_BYTES  = 128,
    parameter int READ_LIMIT = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_rst,
    input  logic       sel,
    input  logic       rx_vld,
    input  logic [7:0] rx_byte,
    output logic       tx_avail,
    output logic [7:0] tx_byte,
    input  logic       tx_take
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam logic [16:0] MEM_END = 17'(MEM_BYTES);
    localparam logic [16:0] LIM     = 17'(READ_LIMIT);
    localparam logic [SP_OW-1:0] SP_LAST = SP_OW'(SP_BYTES - 1);

    sec_state_e state, state_d;

    logic [15:0]      ta;
    logic [SP_OW-1:0] es_end;
    logic             pf, aa;
    logic [SP_OW-1:0] wp;
    logic [15:0]      crc;
    logic [5:0]       cnt;
    logic [15:0]      ptr;
    logic [15:0]      sent;
    logic             oor;

    logic [7:0]  es_byte;
    logic [15:0] crc_in, crc_out;
    logic        sp_we;
    logic [SP_OW-1:0] sp_ridx;
    logic [7:0]  sp_rdata;
    logic        ram_we, ram_re;
    logic [AW-1:0] ram_waddr;
    logic [7:0]  ram_rdata;
    logic        ta_in_range, auth_ok, limit_hit, last_addr;
    logic [7:0]  auth_exp;

    assign es_byte     = {pf, 1'b0, aa, es_end};
    assign ta_in_range = ({1'b0, ta} < MEM_END);
    assign limit_hit   = (LIM != 17'd0) && (({1'b0, sent} + 17'd1) == LIM);
    assign last_addr   = !oor && (({1'b0, ptr} + 17'd1) == MEM_END);

    always_comb begin
        unique case (cnt[1:0])
            2'd0:    auth_exp = ta[7:0];
            2'd1:    auth_exp = ta[15:8];
            default: auth_exp = es_byte;
        endcase
    end
    assign auth_ok = (rx_byte == auth_exp);

    // CRC step over the incoming byte; chain restarts at the opcode
    assign crc_in = (state == S_OPC) ? 16'h0000 : crc;
    sec_crc16_step #(.POLY(CRC_POLY_REF)) u_crc (
        .crc_in (crc_in),
        .din    (rx_byte),
        .crc_out(crc_out)
    );

    assign sp_we   = (state == S_WDATA) && rx_vld && !line_rst;
    assign sp_ridx = (state == S_COPY) ? cnt[SP_OW-1:0] : wp;
    sec_scratch #(.BYTES(SP_BYTES)) u_sp (
        .clk  (clk),
        .we   (sp_we),
        .widx (wp),
        .wdata(rx_byte),
        .ridx (sp_ridx),
        .rdata(sp_rdata)
    );

    assign ram_we    = (state == S_COPY) && !line_rst;
    assign ram_waddr = AW'({ta[15:SP_OW], cnt[SP_OW-1:0]});
    assign ram_re    = (state == S_RFETCH) && !oor;
    sec_sync_ram #(.DEPTH(MEM_BYTES)) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .waddr(ram_waddr),
        .wdata(sp_rdata),
        .re   (ram_re),
        .raddr(ptr[AW-1:0]),
        .rdata(ram_rdata)
    );

    // next-state logic
    always_comb begin
        state_d = state;
        if (line_rst) begin
            state_d = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:   if (sel) state_d = S_OPC;
                S_OPC: if (rx_vld) begin
                    case (rx_byte)
                        OP_WRITE_SP: state_d = S_WA_LO;
                        OP_READ_SP:  state_d = S_RS;
                        OP_COPY_SP:  state_d = S_CA;
                        OP_READ_MEM: state_d = S_RA_LO;
                        default:     state_d = S_HALT;
                    endcase
                end
                S_WA_LO:  if (rx_vld) state_d = S_WA_HI;
                S_WA_HI:  if (rx_vld) state_d = S_WDATA;
                S_WDATA:  if (rx_vld && wp == SP_LAST) state_d = S_WCRC;
                S_WCRC:   if (tx_take && cnt[0]) state_d = S_HALT;
                S_RS:     if (tx_take && cnt >= 6'd3 && wp == SP_LAST) state_d = S_HALT;
                S_CA: if (rx_vld) begin
                    if (!auth_ok) state_d = S_HALT;
                    else if (cnt == 6'd2) state_d = ta_in_range ? S_COPY : S_HALT;
                end
                S_COPY:   if (cnt == 6'(SP_BYTES - 1)) state_d = S_TOGGLE;
                S_TOGGLE: state_d = S_TOGGLE;
                S_RA_LO:  if (rx_vld) state_d = S_RA_HI;
                S_RA_HI:  if (rx_vld) state_d = S_RFETCH;
                S_RFETCH: state_d = S_RSEND;
                S_RSEND:  if (tx_take) state_d = (limit_hit || last_addr) ? S_HALT : S_RFETCH;
                S_HALT:   state_d = S_HALT;
                default:  state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ta <= '0; es_end <= '0; pf <= 1'b0; aa <= 1'b0; wp <= '0;
            crc <= '0; cnt <= '0; ptr <= '0; sent <= '0; oor <= 1'b0;
        end else if (!line_rst) begin
            unique case (state)
                S_OPC: if (rx_vld) begin
                    crc <= crc_out;
                    cnt <= '0;
                    wp  <= ta[SP_OW-1:0];
                    if (rx_byte == OP_WRITE_SP) begin
                        pf <= 1'b1;
                        aa <= 1'b0;
                    end
                end
                S_WA_LO: if (rx_vld) begin
                    ta[7:0] <= rx_byte;
                    crc     <= crc_out;
                end
                S_WA_HI: if (rx_vld) begin
                    ta[15:8] <= rx_byte;
                    es_end   <= ta[SP_OW-1:0];
                    wp       <= ta[SP_OW-1:0];
                    crc      <= crc_out;
                end
                S_WDATA: if (rx_vld) begin
                    es_end <= wp;
                    crc    <= crc_out;
                    if (wp == SP_LAST) begin
                        pf  <= 1'b0;
                        cnt <= '0;
                    end else begin
                        wp <= wp + 1'b1;
                    end
                end
                S_WCRC: if (tx_take) cnt <= cnt + 1'b1;
                S_RS: if (tx_take) begin
                    if (cnt < 6'd3) cnt <= cnt + 1'b1;
                    else            wp  <= wp + 1'b1;
                end
                S_CA: if (rx_vld && auth_ok) begin
                    if (cnt == 6'd2) begin
                        cnt <= '0;
                        if (ta_in_range) aa <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_COPY:  cnt <= cnt + 1'b1;
                S_RA_LO: if (rx_vld) ptr[7:0] <= rx_byte;
                S_RA_HI: if (rx_vld) begin
                    ptr[15:8] <= rx_byte;
                    oor       <= ({1'b0, rx_byte, ptr[7:0]} >= MEM_END);
                    sent      <= '0;
                end
                S_RSEND: if (tx_take) begin
                    ptr  <= ptr + 1'b1;
                    sent <= sent + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_avail = 1'b0;
        tx_byte  = 8'h00;
        unique case (state)
            S_WCRC: begin
                tx_avail = 1'b1;
                tx_byte  = cnt[0] ? ~crc[15:8] : ~crc[7:0];
            end
            S_RS: begin
                tx_avail = 1'b1;
                case (cnt)
                    6'd0:    tx_byte = ta[7:0];
                    6'd1:    tx_byte = ta[15:8];
                    6'd2:    tx_byte = es_byte;
                    default: tx_byte = sp_rdata;
                endcase
            end
            S_TOGGLE: begin
                tx_avail = 1'b1;
                tx_byte  = TOGGLE_BYTE;
            end
            S_RSEND: begin
                tx_avail = 1'b1;
                tx_byte  = oor ? 8'hFF : ram_rdata;
            end
            default: ;
        endcase
    end

    // R3: partial flag raised by an accepted write command
    p_pf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OPC && rx_vld && rx_byte == OP_WRITE_SP && !line_rst) |=> pf);

    // R12: authorised flag dropped by an accepted write command
    p_aa_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OPC && rx_vld && rx_byte == OP_WRITE_SP && !line_rst) |=> !aa);

    // R4: CRC only offered once the scratchpad is complete
    p_crc_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WCRC) |-> !pf);

    // R6: RAM is written only under accepted authorisation
    p_copy_auth_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> aa);

    // R10: no RAM write for an out-of-range section
    p_copy_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ({1'b0, ta} < MEM_END));

    // R7: a bus reset silences the device on the next cycle
    p_reset_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_rst |=> !tx_avail);
endmodule

// File: tb/scratch_eeprom_ctrl_test.sv
`timescale 1ns/1ps
module scratch_eeprom_ctrl_test;
    localparam int MEM = 128;
    localparam int LIMIT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_rst = 1'b0, sel = 1'b0, rx_vld = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic tx_take = 1'b0, take_lim = 1'b0;
    logic tx_avail, l_avail;
    logic [7:0] tx_byte, l_byte;

    int checks = 0, fails = 0, cyc = 0;

    logic [7:0] m_sp [32];
    logic [7:0] m_mem [MEM];
    logic [15:0] m_ta = 16'h0;
    logic [4:0]  m_es = 5'd0;
    logic        m_pf = 1'b0, m_aa = 1'b0;

    always #2 clk = ~clk;

    scratch_eeprom_ctrl #(.MEM_BYTES(MEM), .READ_LIMIT(0)) uut (
        .clk(clk), .rst_n(rst_n), .line_rst(line_rst), .sel(sel),
        .rx_vld(rx_vld), .rx_byte(rx_byte),
        .tx_avail(tx_avail), .tx_byte(tx_byte), .tx_take(tx_take));

    scratch_eeprom_ctrl #(.MEM_BYTES(MEM), .READ_LIMIT(LIMIT)) uut_lim (
        .clk(clk), .rst_n(rst_n), .line_rst(line_rst), .sel(sel),
        .rx_vld(rx_vld), .rx_byte(rx_byte),
        .tx_avail(l_avail), .tx_byte(l_byte), .tx_take(take_lim));

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] != d[i]) r = (r >> 1) ^ 16'hA001;
            else              r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [7:0] m_esb();
        return {m_pf, 1'b0, m_aa, m_es};
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, act=cycle %0d exp=<150000", cyc);
            summary();
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%02h exp=%02h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_vld = 1'b1; rx_byte = b;
        @(negedge clk); rx_vld = 1'b0;
    endtask

    task automatic txn();
        @(negedge clk); line_rst = 1'b1;
        @(negedge clk); line_rst = 1'b0; sel = 1'b1;
        @(negedge clk); sel = 1'b0;
    endtask

    task automatic recv(input bit lim, output logic [7:0] b);
        int w = 0;
        @(negedge clk);
        while (!(lim ? l_avail : tx_avail) && w < 300) begin
            @(negedge clk); w++;
        end
        if (w >= 300) begin
            b = 8'hxx;
        end else begin
            b = lim ? l_byte : tx_byte;
            if (lim) take_lim = 1'b1; else tx_take = 1'b1;
            @(negedge clk);
            take_lim = 1'b0; tx_take = 1'b0;
        end
    endtask

    task automatic rchk(input bit lim, input string req, input logic [7:0] exp);
        logic [7:0] b;
        recv(lim, b);
        chk(req, b, exp);
    endtask

    task automatic quiet(input bit lim, input int n, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (lim ? l_avail : tx_avail) seen = 1'b1;
        end
        chk(req, {7'd0, seen}, 8'h00);
    endtask

    // write scratchpad: n bytes of seed+13*k from address a
    task automatic wr_sp(input logic [15:0] a, input int n, input logic [7:0] seed);
        logic [15:0] c;
        logic [7:0] d;
        txn();
        send(8'h0F); send(a[7:0]); send(a[15:8]);
        c = crc_upd(16'h0, 8'h0F); c = crc_upd(c, a[7:0]); c = crc_upd(c, a[15:8]);
        m_ta = a; m_pf = 1'b1; m_aa = 1'b0; m_es = a[4:0];
        for (int k = 0; k < n; k++) begin
            d = seed + 8'(13 * k);
            send(d);
            c = crc_upd(c, d);
            m_sp[a[4:0] + 5'(k)] = d;
            m_es = a[4:0] + 5'(k);
        end
        if (int'(a[4:0]) + n == 32) begin
            m_pf = 1'b0;
            rchk(1'b0, "R4 crc low", ~c[7:0]);
            rchk(1'b0, "R4 crc high", ~c[15:8]);
        end else begin
            quiet(1'b0, 12, "R4 no crc on early stop");
        end
    endtask

    task automatic rd_sp(input int ndata, input string req);
        txn();
        send(8'hAA);
        rchk(1'b0, {req, " ta lo"}, m_ta[7:0]);
        rchk(1'b0, {req, " ta hi"}, m_ta[15:8]);
        rchk(1'b0, {req, " status"}, m_esb());
        for (int k = 0; k < ndata; k++)
            rchk(1'b0, {req, " R5 slot"}, m_sp[m_ta[4:0] + 5'(k)]);
        if (ndata == 32 - int'(m_ta[4:0])) quiet(1'b0, 8, "R5 silent after last slot");
    endtask

    task automatic copy(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] es, input bit ok);
        txn();
        send(8'h55); send(lo); send(hi); send(es);
        if (ok) begin
            m_aa = 1'b1;
            for (int i = 0; i < 32; i++) m_mem[{m_ta[6:5], 5'(i)}] = m_sp[i];
            for (int i = 0; i < 3; i++) rchk(1'b0, "R7 toggle pattern", 8'hAA);
            @(negedge clk); line_rst = 1'b1;
            @(negedge clk); line_rst = 1'b0;
            quiet(1'b0, 4, "R7 toggling stops at reset");
        end else begin
            quiet(1'b0, 45, "R6 rejected copy stays silent");
        end
    endtask

    task automatic rd_mem(input bit lim, input logic [15:0] a, input int n, input bit ends, input string req);
        txn();
        send(8'hF0); send(a[7:0]); send(a[15:8]);
        for (int k = 0; k < n; k++) begin
            if (int'(a) + k >= MEM) rchk(lim, req, 8'hFF);
            else                    rchk(lim, req, m_mem[int'(a) + k]);
        end
        if (ends) quiet(lim, 10, {req, " stream end"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tx_avail after reset", {7'd0, tx_avail}, 8'h00);
        rd_sp(0, "R1");

        // R13: unselected bytes have no effect
        @(negedge clk); line_rst = 1'b1;
        @(negedge clk); line_rst = 1'b0;
        send(8'h0F); send(8'h40); send(8'h00); send(8'h55);
        quiet(1'b0, 4, "R13 silent when unselected");
        rd_sp(0, "R13");

        // fill every RAM section through authorised copies (R2 R4 R6)
        for (int s = 0; s < MEM / 32; s++) begin
            wr_sp(16'(s * 32), 32, 8'(s * 40 + 1));
            copy(8'(s * 32), 8'h00, m_esb(), 1'b1);
        end

        // R6 mismatch, then full readback (R2 R5)
        wr_sp(16'h0040, 32, 8'h63);
        copy(8'h40, 8'h00, 8'h1E, 1'b0);
        rd_sp(32, "R6 aa untouched after mismatch");
        copy(8'h40, 8'h00, 8'h1F, 1'b1);
        rd_sp(0, "R6 aa set");

        // R3 R12 R2: partial write from offset 0x13
        wr_sp(16'h0013, 4, 8'hC8);
        rd_sp(13, "R3 R12 partial");

        // R8: stream to end of array
        rd_mem(1'b0, 16'h0070, 16, 1'b1, "R8 memory stream");
        rd_mem(1'b0, 16'h0040, 4, 1'b0, "R8 memory section");
        // R9: limited instance stops after LIMIT bytes
        rd_mem(1'b1, 16'h005E, LIMIT, 1'b1, "R9 limited stream");

        // R10: out-of-range read and copy
        rd_mem(1'b0, 16'h0090, 3, 1'b0, "R10 oor read");
        wr_sp(16'h00A0, 32, 8'h07);
        copy(8'hA0, 8'h00, 8'h1F, 1'b0);
        rd_mem(1'b0, 16'h0020, 6, 1'b0, "R10 aliased section unchanged");

        // R11: unknown opcode
        txn();
        send(8'h3C); send(8'h0F); send(8'h00); send(8'h00); send(8'h11);
        quiet(1'b0, 6, "R11 silent after unknown opcode");
        rd_sp(32, "R11 registers unchanged");

        summary();
    end
endmodule